// File: doc/BRIEF.md
# Ring-Buffer Delay Address Generator

This block turns the per-instruction memory commands of an audio signal processor into word addresses for delay lines kept in an external memory. A table of signed-free 16-bit offsets is filled by a host while the processor is stopped. When the processor runs, each table access takes the next offset in program order and adds it to a ring pointer. The ring pointer moves up by one word each sample period, so a fixed offset walks through memory one word per sample and wraps at the top. Because every tap moves at the same rate, the distance between two offsets is a delay measured in samples.

A direct address taken from the internal data bus can stand in for a table entry. It may be used for an access two instruction steps after it is loaded, and such an access leaves the table position where it was. While running, a background update can rewrite a run of up to sixteen consecutive table entries. Each new word arrives as a data beat, and the update ends by itself after its last beat. The block issues one read or write request per accepted access. Driving the memory pins and refreshing the memory are left to a neighbouring block.

Top module: `dly_addr_gen`

## Requirements
- R1: With rst_n low at a clock edge, mem_rd, mem_wr and upd_busy are 0 after that edge, and the ring pointer and table position return to zero.
- R2: While run is 0, a host write (host_we=1) stores host_data into entry host_idx (indices 0 to 39). While run is 1, host writes have no effect on the table.
- R3: A table access is an op of 1 (read) or 2 (write) with use_direct=0 while run=1. On the edge after it, mem_rd (op 1) or mem_wr (op 2) is 1 for one cycle and mem_addr = (entry + ring pointer) mod 2^16. The table position then steps by one, from entry 39 back to 0, and mem_rd and mem_wr are never both 1.
- R4: The ring pointer is 0 while run is 0. While run is 1, it rises by one for each cycle with sample_tick=1, modulo 2^16. Such a cycle also returns the table position to entry 0 for the next access. An access in the same cycle still uses the old pointer and position.
- R5: A write through offset W and a read through offset R issued (W-R) sample ticks later produce the same mem_addr.
- R6: dadr_load=1 captures dbus. A direct access (use_direct=1, op 1 or 2) at least two cycles after the last load gives mem_addr = the captured value and the matching request. It does not move the table position.
- R7: A direct access in the cycle right after a load, or with no load since run rose, issues no request.
- R8: upd_start=1 while run=1 and upd_busy=0 begins an update of upd_len_m1+1 entries starting at upd_base (below 40). upd_busy is 1 from the next edge. Each cycle with upd_wvalid=1 writes upd_wdata into the next entry in increasing order, from 39 back to 0. upd_busy returns to 0 on the edge of the last beat. A start while run is 0 is ignored.
- R9: When an update beat writes the entry that a table access reads in the same cycle, the access uses the old value. The new value is used on the next pass.
- R10: While run is 0, or with op 0, no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | 1 while the processor runs, 0 while stopped for loading |
| sample_tick | input | 1 | One-cycle pulse per sample period |
| host_we | input | 1 | Host table write strobe |
| host_idx | input | 6 | Host table entry index |
| host_data | input | 16 | Host table entry value |
| op | input | 2 | Access command: 0 none, 1 read, 2 write |
| use_direct | input | 1 | Access uses the direct address instead of the table |
| dadr_load | input | 1 | Capture dbus as the direct address |
| dbus | input | 16 | Internal data bus |
| upd_start | input | 1 | Start a run-time table update |
| upd_base | input | 6 | First entry of the update |
| upd_len_m1 | input | 4 | Number of entries to update, minus one |
| upd_wvalid | input | 1 | Update data beat |
| upd_wdata | input | 16 | Update data |
| mem_addr | output | 16 | Physical word address |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| upd_busy | output | 1 | Update in progress |

## Verification
A table position that is out of step shows on the very next table access, because mem_addr then carries a neighbouring entry's offset. A ring pointer that is wrong shows the same way after the next sample tick, as a constant shift in every address. A direct address that unlocks too early or too late shows as a request that appears or goes missing two cycles after a load. An update counter that is off by one shows as upd_busy falling one beat early or late, or as a table entry that was never rewritten. That entry is read back on the next full pass of table reads.

// File: rtl/dly_pkg.sv
// Shared types for the delay address generator.
// Assumes the op encoding 0 none, 1 read, 2 write; code 3 is treated as none.
package dly_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;
endpackage

// File: rtl/dly_offset_table.sv
// Offset storage: one write port, one combinational read port.
// Assumes wr_idx is below DEPTH when wr_en is 1. A read of the entry written in
// the same cycle returns the old value.
module dly_offset_table #(
    parameter int DEPTH = 40,
    parameter int OFS_W = 16,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [OFS_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [OFS_W-1:0] rd_data
);
    logic [OFS_W-1:0] store [DEPTH];

    // Store one word per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) store[wr_idx] <= wr_data;
    end

    assign rd_data = store[rd_idx];
endmodule

// File: rtl/dly_ring_ptr.sv
// Ring pointer: held at zero while stopped, and one step per sample tick while running.
// Assumes the pointer wraps at 2^ADDR_W.
module dly_ring_ptr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    output logic [ADDR_W-1:0] ptr
);
    // Advance the pointer on each tick while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) ptr <= '0;
        else if (tick)      ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/dly_direct_addr.sv
// Direct address latch with a two-step unlock after each load.
// age: 0 = no load since run, 1 = loaded on the previous edge, 2 = usable.
module dly_direct_addr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load,
    input  logic [ADDR_W-1:0] bus,
    output logic [ADDR_W-1:0] addr,
    output logic              ready
);
    logic [1:0] age;

    // Capture the bus value and restart the unlock count on every load.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            age  <= 2'd0;
            addr <= '0;
        end else if (load) begin
            age  <= 2'd1;
            addr <= bus;
        end else if (age == 2'd1) begin
            age  <= 2'd2;
        end
    end

    assign ready = (age == 2'd2);
endmodule

// File: rtl/dly_upd_seq.sv
// Run-time update sequencer. It walks the entries from base upward, wrapping
// from DEPTH-1 to 0, writes one entry per data beat and clears itself after the
// last beat. Assumes base is below DEPTH; a start with a larger base is ignored.
module dly_upd_seq #(
    parameter int DEPTH = 40,
    parameter int IDX_W = 6,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  logic [IDX_W-1:0] base,
    input  logic [LEN_W-1:0] len_m1,
    input  logic             wvalid,
    output logic             busy,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx
);
    logic [LEN_W-1:0] left;

    assign wr_en  = busy && wvalid;

    // Track the active entry and the beats still to come.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            busy   <= 1'b0;
            wr_idx <= '0;
            left   <= '0;
        end else if (!busy) begin
            if (start && (base < IDX_W'(DEPTH))) begin
                busy   <= 1'b1;
                wr_idx <= base;
                left   <= len_m1;
            end
        end else if (wvalid) begin
            wr_idx <= (wr_idx == IDX_W'(DEPTH - 1)) ? '0 : wr_idx + 1'b1;
            if (left == '0) busy <= 1'b0;
            else            left <= left - 1'b1;
        end
    end
endmodule

// File: rtl/dly_addr_gen.sv
// Delay address generator top. It combines the table, the ring pointer, the
// direct address and the update sequencer into registered memory requests.
// Assumes OFS_W <= ADDR_W. Host writes apply only while stopped, updates only while running.
module dly_addr_gen #(
    parameter int DEPTH   = 40,
    parameter int OFS_W   = 16,
    parameter int ADDR_W  = 16,
    parameter int MAX_RUN = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int LEN_W  = $clog2(MAX_RUN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              sample_tick,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [OFS_W-1:0]  host_data,
    input  logic [1:0]        op,
    input  logic              use_direct,
    input  logic              dadr_load,
    input  logic [ADDR_W-1:0] dbus,
    input  logic              upd_start,
    input  logic [IDX_W-1:0]  upd_base,
    input  logic [LEN_W-1:0]  upd_len_m1,
    input  logic              upd_wvalid,
    input  logic [OFS_W-1:0]  upd_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              upd_busy
);
    import dly_pkg::*;

    logic [IDX_W-1:0]  rd_idx_q;
    logic [OFS_W-1:0]  ofs;
    logic [ADDR_W-1:0] ring_q;
    logic [ADDR_W-1:0] daddr;
    logic              dready;
    logic              upd_we;
    logic [IDX_W-1:0]  upd_idx;
    logic              tbl_we;
    logic [IDX_W-1:0]  tbl_widx;
    logic [OFS_W-1:0]  tbl_wdata;
    op_e               op_dec;
    logic              is_rd, is_wr, tbl_acc, dir_acc;

    // Choose the table writer: the host while stopped, the sequencer while running.
    always_comb begin
        if (run) begin
            tbl_we    = upd_we;
            tbl_widx  = upd_idx;
            tbl_wdata = upd_wdata;
        end else begin
            tbl_we    = host_we && (host_idx < IDX_W'(DEPTH));
            tbl_widx  = host_idx;
            tbl_wdata = host_data;
        end
    end

    // Decode the command into table and direct accesses.
    always_comb begin
        op_dec  = op_e'(op);
        is_rd   = (op_dec == OP_READ);
        is_wr   = (op_dec == OP_WRITE);
        tbl_acc = run && (is_rd || is_wr) && !use_direct;
        dir_acc = run && (is_rd || is_wr) && use_direct && dready;
    end

    dly_offset_table #(.DEPTH(DEPTH), .OFS_W(OFS_W), .IDX_W(IDX_W)) i_table (
        .clk(clk), .wr_en(tbl_we), .wr_idx(tbl_widx), .wr_data(tbl_wdata),
        .rd_idx(rd_idx_q), .rd_data(ofs)
    );

    dly_ring_ptr #(.ADDR_W(ADDR_W)) i_ring (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(sample_tick), .ptr(ring_q)
    );

    dly_direct_addr #(.ADDR_W(ADDR_W)) i_direct (
        .clk(clk), .rst_n(rst_n), .run(run), .load(dadr_load), .bus(dbus),
        .addr(daddr), .ready(dready)
    );

    dly_upd_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LEN_W(LEN_W)) i_upd (
        .clk(clk), .rst_n(rst_n), .run(run), .start(upd_start), .base(upd_base),
        .len_m1(upd_len_m1), .wvalid(upd_wvalid), .busy(upd_busy),
        .wr_en(upd_we), .wr_idx(upd_idx)
    );

    // Step the table position in program order and restart it each sample.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  rd_idx_q <= '0;
        else if (sample_tick) rd_idx_q <= '0;
        else if (tbl_acc)     rd_idx_q <= (rd_idx_q == IDX_W'(DEPTH - 1)) ? '0 : rd_idx_q + 1'b1;
    end

    // Register the physical address and the request for each accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_rd   <= 1'b0;
            mem_wr   <= 1'b0;
        end else begin
            mem_rd <= (tbl_acc || dir_acc) && is_rd;
            mem_wr <= (tbl_acc || dir_acc) && is_wr;
            if (dir_acc)      mem_addr <= daddr;
            else if (tbl_acc) mem_addr <= ADDR_W'(ofs) + ring_q;
        end
    end
endmodule

// File: rtl/dly_addr_gen_chk.sv
// Property checker for the delay address generator, attached by bind.
// It watches the requests, the ring pointer, the table position and the update flag.
module dly_addr_gen_chk #(
    parameter int DEPTH  = 40,
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              sample_tick,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              upd_busy,
    input logic              upd_wvalid,
    input logic [ADDR_W-1:0] ptr,
    input logic [IDX_W-1:0]  rd_idx
);
    assert_exclusive_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_idx_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_idx < IDX_W'(DEPTH));

    assert_stopped_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!mem_rd && !mem_wr));

    assert_ptr_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (ptr == '0));

    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sample_tick) |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sample_tick) |=> $stable(ptr));

    assert_busy_ends_on_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(upd_busy) |-> ($past(upd_wvalid) || !$past(run)));
endmodule

bind dly_addr_gen dly_addr_gen_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .sample_tick(sample_tick),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .upd_busy(upd_busy), .upd_wvalid(upd_wvalid),
    .ptr(ring_q), .rd_idx(rd_idx_q)
);

// File: tb/test_dly_addr_gen.sv
// Directed bench for the delay address generator. Inputs change 1 ns after a
// rising edge, and outputs are sampled at that same point after the next edge.
module test_dly_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n, run, sample_tick, host_we, use_direct, dadr_load;
    logic        upd_start, upd_wvalid;
    logic [5:0]  host_idx, upd_base;
    logic [15:0] host_data, dbus, upd_wdata;
    logic [1:0]  op;
    logic [3:0]  upd_len_m1;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, upd_busy;

    int checks = 0;
    int failures = 0;
    logic [15:0] tbl_m [40];
    logic [15:0] ptr_m = 16'd0;

    always #5 clk = ~clk;

    dly_addr_gen i_dly_addr_gen (
        .clk(clk), .rst_n(rst_n), .run(run), .sample_tick(sample_tick),
        .host_we(host_we), .host_idx(host_idx), .host_data(host_data),
        .op(op), .use_direct(use_direct), .dadr_load(dadr_load), .dbus(dbus),
        .upd_start(upd_start), .upd_base(upd_base), .upd_len_m1(upd_len_m1),
        .upd_wvalid(upd_wvalid), .upd_wdata(upd_wdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .upd_busy(upd_busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic access(input logic [1:0] o, input logic dir);
        op = o; use_direct = dir;
        step();
        op = 2'd0; use_direct = 1'b0;
    endtask

    task automatic tick();
        sample_tick = 1'b1;
        step();
        sample_tick = 1'b0;
        if (run) ptr_m = ptr_m + 16'd1;
    endtask

    task automatic host_wr(input int idx, input logic [15:0] d);
        host_we = 1'b1; host_idx = 6'(idx); host_data = d;
        step();
        host_we = 1'b0;
        if (!run) tbl_m[idx] = d;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        chk("R1 rd", {31'd0, mem_rd}, 32'd0);
        chk("R1 wr", {31'd0, mem_wr}, 32'd0);
        chk("R1 busy", {31'd0, upd_busy}, 32'd0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_load_stopped();
        for (int i = 0; i < 40; i++) begin
            logic [15:0] v;
            v = 16'(i * 16'h0123);
            if (i == 0) v = 16'h2000;
            if (i == 1) v = 16'h1000;
            if (i == 2) v = 16'hFFFF;
            host_wr(i, v);
        end
        access(2'd1, 1'b0);
        chk("R10 stopped read", {31'd0, mem_rd}, 32'd0);
        upd_start = 1'b1; upd_base = 6'd5; upd_len_m1 = 4'd0;
        step();
        upd_start = 1'b0;
        chk("R8 start ignored while stopped", {31'd0, upd_busy}, 32'd0);
    endtask

    task automatic t_basic();
        run = 1'b1;
        step();
        access(2'd2, 1'b0);
        chk("R3 write req", {31'd0, mem_wr}, 32'd1);
        chk("R3 write addr", {16'd0, mem_addr}, {16'd0, tbl_m[0] + ptr_m});
        access(2'd1, 1'b0);
        chk("R3 read req", {30'd0, mem_rd, mem_wr}, 32'd2);
        chk("R3 read addr", {16'd0, mem_addr}, {16'd0, tbl_m[1] + ptr_m});
        access(2'd0, 1'b0);
        chk("R10 op none", {30'd0, mem_rd, mem_wr}, 32'd0);
        host_wr(2, 16'hDEAD);
        tick();
        access(2'd1, 1'b0);
        access(2'd1, 1'b0);
        access(2'd1, 1'b0);
        chk("R2 host write ignored while running", {16'd0, mem_addr}, {16'd0, 16'hFFFF + ptr_m});
        chk("R3 wrap of sum", {16'd0, mem_addr}, {16'd0, 16'h0000});
    endtask

    task automatic t_full_pass();
        tick();
        chk("R4 pointer advanced", 32'(ptr_m), 32'd2);
        for (int i = 0; i < 40; i++) begin
            access(2'd1, 1'b0);
            if (mem_addr !== tbl_m[i] + ptr_m)
                chk("R3 pass entry", {16'd0, mem_addr}, {16'd0, tbl_m[i] + ptr_m});
        end
        checks++;
        access(2'd1, 1'b0);
        chk("R3 position wraps to entry 0", {16'd0, mem_addr}, {16'd0, tbl_m[0] + ptr_m});
    endtask

    task automatic t_delay();
        logic [15:0] waddr;
        tick();
        access(2'd2, 1'b0);
        waddr = mem_addr;
        for (int i = 0; i < 16'h1000; i++) tick();
        access(2'd1, 1'b0);
        access(2'd1, 1'b0);
        chk("R5 read meets write", {16'd0, mem_addr}, {16'd0, waddr});
        chk("R4 tick restarts position", {16'd0, mem_addr}, {16'd0, tbl_m[1] + ptr_m});
    endtask

    task automatic t_direct();
        tick();
        access(2'd1, 1'b0);
        dadr_load = 1'b1; dbus = 16'h4321;
        step();
        dadr_load = 1'b0;
        access(2'd2, 1'b1);
        chk("R7 too early no req", {30'd0, mem_rd, mem_wr}, 32'd0);
        access(2'd2, 1'b1);
        chk("R6 direct write req", {31'd0, mem_wr}, 32'd1);
        chk("R6 direct addr", {16'd0, mem_addr}, {16'd0, 16'h4321});
        access(2'd1, 1'b0);
        chk("R6 position kept", {16'd0, mem_addr}, {16'd0, tbl_m[1] + ptr_m});
    endtask

    task automatic t_update();
        upd_start = 1'b1; upd_base = 6'd38; upd_len_m1 = 4'd2;
        step();
        upd_start = 1'b0;
        chk("R8 busy after start", {31'd0, upd_busy}, 32'd1);
        upd_wvalid = 1'b1;
        upd_wdata = 16'hA001; step();
        upd_wdata = 16'hA002; step();
        chk("R8 busy before last beat", {31'd0, upd_busy}, 32'd1);
        upd_wdata = 16'hA003; step();
        upd_wvalid = 1'b0;
        chk("R8 busy clears after last beat", {31'd0, upd_busy}, 32'd0);
        tbl_m[38] = 16'hA001; tbl_m[39] = 16'hA002; tbl_m[0] = 16'hA003;
        upd_wvalid = 1'b1; upd_wdata = 16'hBEEF; step(); upd_wvalid = 1'b0;
        tick();
        for (int i = 0; i < 40; i++) begin
            access(2'd1, 1'b0);
            if (i == 0 || i == 38 || i == 39)
                chk("R8 updated entry", {16'd0, mem_addr}, {16'd0, tbl_m[i] + ptr_m});
        end
    endtask

    task automatic t_collision();
        tick();
        upd_start = 1'b1; upd_base = 6'd0; upd_len_m1 = 4'd0;
        step();
        upd_start = 1'b0;
        upd_wvalid = 1'b1; upd_wdata = 16'h7777;
        access(2'd1, 1'b0);
        upd_wvalid = 1'b0;
        chk("R9 old entry used", {16'd0, mem_addr}, {16'd0, tbl_m[0] + ptr_m});
        tbl_m[0] = 16'h7777;
        tick();
        access(2'd1, 1'b0);
        chk("R9 new entry next pass", {16'd0, mem_addr}, {16'd0, tbl_m[0] + ptr_m});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; run = 1'b0; sample_tick = 1'b0; host_we = 1'b0;
        host_idx = '0; host_data = '0; op = 2'd0; use_direct = 1'b0;
        dadr_load = 1'b0; dbus = '0; upd_start = 1'b0; upd_base = '0;
        upd_len_m1 = '0; upd_wvalid = 1'b0; upd_wdata = '0;
        #1;
        t_reset();
        t_load_stopped();
        t_basic();
        t_full_pass();
        t_delay();
        t_direct();
        t_update();
        t_collision();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule